// File: doc/BRIEF.md
# Paged Memory Window Mapper

This block steers the processor's memory cycles in the top part of a 20-bit address space onto a larger backing store. A 64 KB window at E0000h–EFFFFh can be opened onto any one of 64 blocks of 64 KB each. The low-numbered blocks live in battery-backed SRAM and the rest live in flash. The top 64 KB of the address space, F0000h–FFFFFh, is always routed to the boot ROM, whatever the window holds.

One 8-bit control register is loaded and read back over a plain register port. Its top bit opens the window. Its low six bits name the block shown in the window. The bit between them is unused. For every memory cycle the block decides from the address and the register which device, if any, is selected. It also forms the device address. The decode is combinational from the address, so a cycle is steered in the same clock in which it is presented.

Top module: `page_window_mapper`

## Requirements
- R1: After reset the control register reads 00h and no address in E0000h–EFFFFh produces a window hit.
- R2: While register bit 7 is 0, a cycle addressed to E0000h–EFFFFh asserts none of win_hit, sram_cs or flash_cs.
- R3: Register bit 6 always reads back as 0, and the value written there has no effect on selection or on the backing-store address.
- R4: On a window hit, bs_addr equals the 6-bit block number from register bits 5..0 placed above the 16 low address bits, i.e. {page, mem_addr[15:0]}.
- R5: On a window hit with block number 0..7 (top three block bits 000), sram_cs is 1 and flash_cs is 0.
- R6: On a window hit with block number 8..63, flash_cs is 1 and sram_cs is 0.
- R7: A cycle addressed to F0000h–FFFFFh asserts rom_cs with rom_addr equal to mem_addr[15:0], and never win_hit, whatever the register holds.
- R8: A cycle addressed below E0000h asserts none of win_hit, sram_cs, flash_cs or rom_cs.
- R9: A register write is seen by cycles from the clock edge that stores it onward and not before it, and a read returns the stored value.
- R10: While mem_req is 0 no select output is asserted, and at most one of sram_cs, flash_cs and rom_cs is ever 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Load the control register at the next clock edge |
| reg_wdata | input | 8 | Value to load: bit 7 window open, bits 5..0 block number |
| reg_rdata | output | 8 | Stored control value, bit 6 reading 0 |
| mem_req | input | 1 | A memory cycle is being presented |
| mem_addr | input | 20 | Processor memory address of the cycle |
| win_hit | output | 1 | Cycle falls in the open window |
| sram_cs | output | 1 | Select for the battery-backed SRAM |
| flash_cs | output | 1 | Select for the paged flash |
| rom_cs | output | 1 | Select for the fixed boot ROM region |
| bs_addr | output | 22 | Backing-store address on a window hit, zero otherwise |
| rom_addr | output | 16 | Offset within the boot ROM region, zero otherwise |

## Verification
The bench goes after the edges of the window: EFFFFh must hit while DFFFFh and F0000h must not. A mapper that compared one bit too few would spill into the ROM or the region below. Blocks 7 and 8 are the border between SRAM and flash, and block 63 is the top. A design that tested the wrong block bits would select the wrong chip or both chips there. Writing bit 6 set, then clear, shows whether the spare bit leaks into read-back or into the block number. A check taken just before the storing edge catches a mapper that passes the write data straight through instead of using the stored value.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int CPU_AW     = 20;
    localparam int OFS_W      = 16;
    localparam int PAGE_W     = 6;
    localparam int REG_W      = 8;
    localparam int TAG_W      = CPU_AW - OFS_W;
    localparam int BS_AW      = PAGE_W + OFS_W;
    localparam int EN_BIT     = 7;
    localparam int SPARE_BIT  = 6;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_WIN  = 2'd1,
        RG_ROM  = 2'd2
    } region_e;

    typedef enum logic [1:0] {
        TG_NONE  = 2'd0,
        TG_SRAM  = 2'd1,
        TG_FLASH = 2'd2,
        TG_ROM   = 2'd3
    } target_e;

    typedef struct packed {
        logic              open;
        logic [PAGE_W-1:0] page;
    } win_cfg_t;

    typedef struct packed {
        target_e           tgt;
        logic [BS_AW-1:0]  addr;
        logic [OFS_W-1:0]  rom_ofs;
    } route_t;

    function automatic logic page_in_sram(input logic [PAGE_W-1:0] page, input int sel_w);
        logic hit;
        hit = 1'b1;
        for (int i = PAGE_W - 1; i >= 0; i--) begin
            if (i >= PAGE_W - sel_w && page[i]) hit = 1'b0;
        end
        return hit;
    endfunction

endpackage

// File: rtl/pwm_ctrl_reg.sv
module pwm_ctrl_reg
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output win_cfg_t         cfg,
    output logic [REG_W-1:0] rdata
);

    win_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q.open <= wdata[EN_BIT];
            cfg_q.page <= wdata[PAGE_W-1:0];
        end
    end

    always_comb begin
        rdata            = '0;
        rdata[EN_BIT]    = cfg_q.open;
        rdata[SPARE_BIT] = 1'b0;
        rdata[PAGE_W-1:0] = cfg_q.page;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/pwm_region_decode.sv
module pwm_region_decode
    import pwm_pkg::*;
#(
    parameter logic [TAG_W-1:0] WIN_TAG = 4'hE,
    parameter logic [TAG_W-1:0] ROM_TAG = 4'hF
) (
    input  logic              req,
    input  logic [CPU_AW-1:0] addr,
    input  logic              win_open,
    output region_e           region
);

    logic [TAG_W-1:0] tag;
    assign tag = addr[CPU_AW-1:OFS_W];

    always_comb begin
        region = RG_NONE;
        if (req) begin
            if (tag == ROM_TAG)                  region = RG_ROM;
            else if (tag == WIN_TAG && win_open) region = RG_WIN;
        end
    end

endmodule

// File: rtl/pwm_route.sv
module pwm_route
    import pwm_pkg::*;
#(
    parameter int SRAM_SEL_W = 3
) (
    input  region_e           region,
    input  logic [PAGE_W-1:0] page,
    input  logic [OFS_W-1:0]  ofs,
    output route_t            route
);

    logic to_sram;
    assign to_sram = page_in_sram(page, SRAM_SEL_W);

    always_comb begin
        route = '{tgt: TG_NONE, addr: '0, rom_ofs: '0};
        unique case (region)
            RG_WIN: begin
                route.tgt  = to_sram ? TG_SRAM : TG_FLASH;
                route.addr = {page, ofs};
            end
            RG_ROM: begin
                route.tgt     = TG_ROM;
                route.rom_ofs = ofs;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/page_window_mapper.sv
module page_window_mapper
    import pwm_pkg::*;
#(
    parameter logic [TAG_W-1:0] WIN_TAG    = 4'hE,
    parameter logic [TAG_W-1:0] ROM_TAG    = 4'hF,
    parameter int               SRAM_SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              mem_req,
    input  logic [CPU_AW-1:0] mem_addr,
    output logic              win_hit,
    output logic              sram_cs,
    output logic              flash_cs,
    output logic              rom_cs,
    output logic [BS_AW-1:0]  bs_addr,
    output logic [OFS_W-1:0]  rom_addr
);

    win_cfg_t cfg;
    region_e  region;
    route_t   route;

    pwm_ctrl_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .wdata (reg_wdata),
        .cfg   (cfg),
        .rdata (reg_rdata)
    );

    pwm_region_decode #(
        .WIN_TAG (WIN_TAG),
        .ROM_TAG (ROM_TAG)
    ) u_dec (
        .req      (mem_req),
        .addr     (mem_addr),
        .win_open (cfg.open),
        .region   (region)
    );

    pwm_route #(
        .SRAM_SEL_W (SRAM_SEL_W)
    ) u_route (
        .region (region),
        .page   (cfg.page),
        .ofs    (mem_addr[OFS_W-1:0]),
        .route  (route)
    );

    assign win_hit  = (region == RG_WIN);
    assign sram_cs  = (route.tgt == TG_SRAM);
    assign flash_cs = (route.tgt == TG_FLASH);
    assign rom_cs   = (route.tgt == TG_ROM);
    assign bs_addr  = route.addr;
    assign rom_addr = route.rom_ofs;

endmodule

// File: rtl/pwm_checker.sv
module pwm_checker
    import pwm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              mem_req,
    input logic [CPU_AW-1:0] mem_addr,
    input logic              win_hit,
    input logic              sram_cs,
    input logic              flash_cs,
    input logic              rom_cs,
    input logic [BS_AW-1:0]  bs_addr
);

    logic [TAG_W-1:0] tag;
    assign tag = mem_addr[CPU_AW-1:OFS_W];

    a_r2_closed_no_hit: assert property (@(posedge clk) disable iff (rst)
        !reg_rdata[EN_BIT] |-> !(win_hit || sram_cs || flash_cs));

    a_r3_spare_reads_zero: assert property (@(posedge clk) disable iff (rst)
        !reg_rdata[SPARE_BIT]);

    a_r4_addr_form: assert property (@(posedge clk) disable iff (rst)
        win_hit |-> bs_addr == {reg_rdata[PAGE_W-1:0], mem_addr[OFS_W-1:0]});

    a_r5_sram_low_pages: assert property (@(posedge clk) disable iff (rst)
        (win_hit && reg_rdata[PAGE_W-1:PAGE_W-3] == 3'b000) |-> (sram_cs && !flash_cs));

    a_r6_flash_high_pages: assert property (@(posedge clk) disable iff (rst)
        (win_hit && reg_rdata[PAGE_W-1:PAGE_W-3] != 3'b000) |-> (flash_cs && !sram_cs));

    a_r7_rom_fixed: assert property (@(posedge clk) disable iff (rst)
        (mem_req && tag == 4'hF) |-> (rom_cs && !win_hit));

    a_r8_low_space_quiet: assert property (@(posedge clk) disable iff (rst)
        (tag < 4'hE) |-> !(win_hit || sram_cs || flash_cs || rom_cs));

    a_r9_write_stored: assert property (@(posedge clk) disable iff (rst)
        ($past(reg_we) && !$past(rst)) |->
            reg_rdata == ($past(reg_wdata) & 8'hBF));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !mem_req |-> !(win_hit || sram_cs || flash_cs || rom_cs));

    a_r10_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sram_cs, flash_cs, rom_cs}));

endmodule

bind page_window_mapper pwm_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .win_hit   (win_hit),
    .sram_cs   (sram_cs),
    .flash_cs  (flash_cs),
    .rom_cs    (rom_cs),
    .bs_addr   (bs_addr)
);

// File: tb/sim_page_window_mapper.sv
`timescale 1ns/1ps
module sim_page_window_mapper;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        mem_req = 1'b0;
    logic [19:0] mem_addr = 20'h0;
    logic        win_hit, sram_cs, flash_cs, rom_cs;
    logic [21:0] bs_addr;
    logic [15:0] rom_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    page_window_mapper u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .win_hit(win_hit), .sram_cs(sram_cs), .flash_cs(flash_cs),
        .rom_cs(rom_cs), .bs_addr(bs_addr), .rom_addr(rom_addr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // present a cycle and compare selects {win,sram,flash,rom} and addresses
    task automatic probe(input string req, input logic [19:0] a, input logic rq,
                         input logic [3:0] exp_sel, input logic [21:0] exp_bs,
                         input logic [15:0] exp_rom);
        logic [3:0] sel;
        mem_addr = a;
        mem_req = rq;
        #2;
        sel = {win_hit, sram_cs, flash_cs, rom_cs};
        chk(sel == exp_sel, req, {28'h0, sel}, {28'h0, exp_sel});
        chk(bs_addr == exp_bs, req, {10'h0, bs_addr}, {10'h0, exp_bs});
        chk(rom_addr == exp_rom, req, {16'h0, rom_addr}, {16'h0, exp_rom});
        mem_req = 1'b0;
    endtask

    task automatic t_reset;
        chk(reg_rdata == 8'h00, "R1", {24'h0, reg_rdata}, 32'h0);
        probe("R1", 20'hE1234, 1'b1, 4'b0000, 22'h0, 16'h0);
    endtask

    task automatic t_closed;
        write_reg(8'h05);
        chk(reg_rdata == 8'h05, "R9", {24'h0, reg_rdata}, 32'h05);
        probe("R2", 20'hE1234, 1'b1, 4'b0000, 22'h0, 16'h0);
        probe("R2", 20'hEFFFF, 1'b1, 4'b0000, 22'h0, 16'h0);
    endtask

    task automatic t_sram;
        write_reg(8'h83);
        probe("R5", 20'hE1234, 1'b1, 4'b1100, {6'd3, 16'h1234}, 16'h0);
        write_reg(8'h80);
        probe("R4", 20'hE0000, 1'b1, 4'b1100, {6'd0, 16'h0000}, 16'h0);
        write_reg(8'h87);
        probe("R5", 20'hEFFFF, 1'b1, 4'b1100, {6'd7, 16'hFFFF}, 16'h0);
    endtask

    task automatic t_flash;
        write_reg(8'h88);
        probe("R6", 20'hE0001, 1'b1, 4'b1010, {6'd8, 16'h0001}, 16'h0);
        write_reg(8'hBF);
        probe("R6", 20'hEABCD, 1'b1, 4'b1010, {6'd63, 16'hABCD}, 16'h0);
        write_reg(8'h95);
        probe("R4", 20'hE5A5A, 1'b1, 4'b1010, {6'd21, 16'h5A5A}, 16'h0);
    endtask

    task automatic t_spare;
        write_reg(8'hC5);
        chk(reg_rdata == 8'h85, "R3", {24'h0, reg_rdata}, 32'h85);
        probe("R3", 20'hE0100, 1'b1, 4'b1100, {6'd5, 16'h0100}, 16'h0);
        write_reg(8'h45);
        chk(reg_rdata == 8'h05, "R3", {24'h0, reg_rdata}, 32'h05);
        probe("R3", 20'hE0100, 1'b1, 4'b0000, 22'h0, 16'h0);
    endtask

    task automatic t_rom;
        write_reg(8'h00);
        probe("R7", 20'hF0000, 1'b1, 4'b0001, 22'h0, 16'h0000);
        write_reg(8'hAA);
        probe("R7", 20'hFFFFF, 1'b1, 4'b0001, 22'h0, 16'hFFFF);
        probe("R7", 20'hF1234, 1'b1, 4'b0001, 22'h0, 16'h1234);
    endtask

    task automatic t_low;
        write_reg(8'h83);
        probe("R8", 20'hDFFFF, 1'b1, 4'b0000, 22'h0, 16'h0);
        probe("R8", 20'h00000, 1'b1, 4'b0000, 22'h0, 16'h0);
        probe("R8", 20'h6E000, 1'b1, 4'b0000, 22'h0, 16'h0);
    endtask

    task automatic t_idle;
        write_reg(8'h8C);
        probe("R10", 20'hE4444, 1'b0, 4'b0000, 22'h0, 16'h0);
        probe("R10", 20'hF4444, 1'b0, 4'b0000, 22'h0, 16'h0);
    endtask

    task automatic t_timing;
        write_reg(8'h82);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = 8'h90;
        // before the storing edge the old block (2, SRAM) must still apply
        probe("R9", 20'hE0042, 1'b1, 4'b1100, {6'd2, 16'h0042}, 16'h0);
        @(negedge clk);
        reg_we = 1'b0;
        chk(reg_rdata == 8'h90, "R9", {24'h0, reg_rdata}, 32'h90);
        probe("R9", 20'hE0042, 1'b1, 4'b1010, {6'd16, 16'h0042}, 16'h0);
    endtask

    task automatic t_reset_again;
        write_reg(8'hFF);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(reg_rdata == 8'h00, "R1", {24'h0, reg_rdata}, 32'h0);
        probe("R1", 20'hE0000, 1'b1, 4'b0000, 22'h0, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_closed();
        t_sram();
        t_flash();
        t_spare();
        t_rom();
        t_low();
        t_idle();
        t_timing();
        t_reset_again();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule